// File: doc/BRIEF.md
# Audio Clock Ratio Desync Monitor

The monitor runs in the fast PLL clock domain. It checks that the serial audio frame clock (LRCK) stays locked in ratio to the PLL clock. LRCK is brought into the PLL domain through a synchroniser, and its rising edges mark period boundaries. The number of PLL cycles in each LRCK period is counted and compared with a window of plus or minus 4 around a ratio N, which software sets. A period that falls outside the window is a desync event. So is a PLL that reports loss of lock, and so is an LRCK that stops long enough for the counter to saturate.

While the monitor is out of sync and detection is enabled, it drives a hard mute to the audio output path and a freeze to the processing pipeline. Mute has no ramp. A sticky status bit records every desync event until a clear pulse removes it. The outputs come back only after two consecutive judged periods fall inside the window with lock asserted. The first period after reset, and the first period after lock returns, is discarded because it is only partly measured.

Top module: `clk_ratio_mon`

## Requirements
- R1: While reset is active and at the first clock after reset, in_sync_o is 0, stat_sticky_o is 0, and mute_o and freeze_o are 1.
- R2: The length of a period is the number of PLL clock edges between two successive synchronised LRCK rising edges. A length from N-4 to N+4 inclusive counts as a good period.
- R3: A judged period of N-5 or less, or of N+5 or more, is a bad period. It drops in_sync_o at the edge where the period closes.
- R4: When pll_lock_i is 0, in_sync_o drops on the next clock edge. The monitor also disarms, so no period is judged until lock returns.
- R5: After reset, and after lock returns, the first LRCK rising edge only re-arms the monitor. The period that this edge closes is not judged.
- R6: in_sync_o rises only on the second consecutive good period. Any bad event resets the run of good periods.
- R7: mute_o and freeze_o are registered, and each equals det_en_i AND NOT the next sync state. They therefore rise on the same edge where in_sync_o falls.
- R8: While det_en_i is 0, mute_o and freeze_o stay 0 one clock later, even across desync events. stat_sticky_o still records those events.
- R9: The period counter saturates at 2^CNT_W-1 and never wraps. While it is saturated the monitor is out of sync, so a stopped LRCK is reported.
- R10: stat_sticky_o is set by any desync event and holds until stat_clr_i is pulsed. A desync event in the same cycle as the clear wins.
- R11: ratio_n_i can change at run time. Periods judged after the change are compared with the new N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lrck_i | input | 1 | Asynchronous serial audio frame clock |
| pll_lock_i | input | 1 | PLL lock indication |
| ratio_n_i | input | CNT_W | Expected PLL cycles per LRCK period |
| det_en_i | input | 1 | Desync detection enable for mute and freeze |
| stat_clr_i | input | 1 | Clear pulse for the sticky status |
| mute_o | output | 1 | Immediate mute to the audio output path |
| freeze_o | output | 1 | Freeze to the processing pipeline |
| in_sync_o | output | 1 | Monitor currently judges the clocks synchronous |
| stat_sticky_o | output | 1 | A desync event has occurred since the last clear |

## Verification
Square-wave LRCK trains are driven at the nominal ratio and at N-4, N+4, N-5 and N+5. This shows that both window edges are inclusive, and that exactly one cycle beyond either edge is rejected. Short drops of lock placed inside an otherwise in-window period reveal whether the re-arm period is discarded: the bench counts the rising edges needed before sync returns. A held LRCK separates saturation from wraparound. Runs with detection disabled, and runs with a new N, show that gating and the ratio apply to mute and to the status independently.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam int unsigned CRM_TOL = 4;
  localparam int unsigned CRM_REL = 2;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } crm_ev_e;
endpackage

// File: rtl/crm_lrck_sync.sv
module crm_lrck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= lrck_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/crm_period_cnt.sv
module crm_period_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign sat_o   = (cnt_q == CNT_MAX);
  assign cnt_inc = sat_o ? CNT_MAX : cnt_q + 1'b1;
  assign meas_o  = cnt_inc;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (rise_i) cnt_q <= '0;
    else             cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/crm_window.sv
module crm_window #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TOL   = 4
) (
  input  logic [CNT_W-1:0] meas_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             in_win_o
);
  localparam int unsigned EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] TOL_E = EXT_W'(TOL);

  logic [EXT_W-1:0] meas_e, ratio_e;
  logic             lo_ok, hi_ok;

  assign meas_e   = {1'b0, meas_i};
  assign ratio_e  = {1'b0, ratio_i};
  assign lo_ok    = (meas_e + TOL_E) >= ratio_e;
  assign hi_ok    = meas_e <= (ratio_e + TOL_E);
  assign in_win_o = lo_ok & hi_ok;
endmodule

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
#(
  parameter int unsigned REL = CRM_REL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic rise_i,
  input  logic in_win_i,
  input  logic sat_i,
  input  logic det_en_i,
  input  logic clr_i,
  output logic in_sync_o,
  output logic sticky_o,
  output logic mute_o,
  output logic freeze_o
);
  localparam int unsigned GW = $clog2(REL + 1);
  localparam logic [GW-1:0] REL_V = GW'(REL);

  logic          armed_q, sync_q, sync_d, sticky_q, mute_q, frz_q;
  logic [GW-1:0] good_q, good_d;
  crm_ev_e       ev;

  always_comb begin
    ev = EV_NONE;
    if (!lock_i || sat_i)                ev = EV_BAD;
    else if (rise_i && armed_q)          ev = in_win_i ? EV_GOOD : EV_BAD;
  end

  always_comb begin
    good_d = good_q;
    sync_d = sync_q;
    unique case (ev)
      EV_BAD: begin
        good_d = '0;
        sync_d = 1'b0;
      end
      EV_GOOD: begin
        if (good_q < REL_V) good_d = good_q + 1'b1;
        if (good_q + 1'b1 >= REL_V) sync_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      good_q   <= '0;
      sync_q   <= 1'b0;
      sticky_q <= 1'b0;
      mute_q   <= 1'b1;
      frz_q    <= 1'b1;
    end else begin
      if (!lock_i)     armed_q <= 1'b0;
      else if (rise_i) armed_q <= 1'b1;
      good_q <= good_d;
      sync_q <= sync_d;
      if (ev == EV_BAD) sticky_q <= 1'b1;
      else if (clr_i)   sticky_q <= 1'b0;
      mute_q <= det_en_i & ~sync_d;
      frz_q  <= det_en_i & ~sync_d;
    end
  end

  assign in_sync_o = sync_q;
  assign sticky_o  = sticky_q;
  assign mute_o    = mute_q;
  assign freeze_o  = frz_q;
endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon
  import crm_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned TOL     = CRM_TOL,
  parameter int unsigned REL     = CRM_REL,
  parameter int unsigned STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  input  logic             pll_lock_i,
  input  logic [CNT_W-1:0] ratio_n_i,
  input  logic             det_en_i,
  input  logic             stat_clr_i,
  output logic             mute_o,
  output logic             freeze_o,
  output logic             in_sync_o,
  output logic             stat_sticky_o
);
  logic             lrck_rise;
  logic [CNT_W-1:0] period_cnt;
  logic [CNT_W-1:0] period_meas;
  logic             cnt_sat;
  logic             in_win;

  crm_lrck_sync #(.STAGES(STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lrck_i(lrck_i),
    .rise_o(lrck_rise)
  );

  crm_period_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(lrck_rise),
    .cnt_o (period_cnt),
    .meas_o(period_meas),
    .sat_o (cnt_sat)
  );

  crm_window #(.CNT_W(CNT_W), .TOL(TOL)) i_win (
    .meas_i  (period_meas),
    .ratio_i (ratio_n_i),
    .in_win_o(in_win)
  );

  crm_ctrl #(.REL(REL)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (pll_lock_i),
    .rise_i   (lrck_rise),
    .in_win_i (in_win),
    .sat_i    (cnt_sat),
    .det_en_i (det_en_i),
    .clr_i    (stat_clr_i),
    .in_sync_o(in_sync_o),
    .sticky_o (stat_sticky_o),
    .mute_o   (mute_o),
    .freeze_o (freeze_o)
  );
endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pll_lock_i,
  input logic             det_en_i,
  input logic             stat_clr_i,
  input logic             lrck_rise,
  input logic [CNT_W-1:0] period_cnt,
  input logic             in_sync_o,
  input logic             mute_o,
  input logic             freeze_o,
  input logic             stat_sticky_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_lock_loss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> (!in_sync_o && stat_sticky_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> $past(lrck_rise && pll_lock_i));

  assert_mute_at_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(in_sync_o) && $past(det_en_i)) |-> (mute_o && freeze_o));

  assert_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> (!mute_o && !freeze_o));

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_cnt == CNT_MAX && !lrck_rise) |=> (period_cnt == CNT_MAX));

  assert_sticky_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_sticky_o && !stat_clr_i) |=> stat_sticky_o);
endmodule

bind clk_ratio_mon crm_checker #(.CNT_W(CNT_W)) i_crm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pll_lock_i   (pll_lock_i),
  .det_en_i     (det_en_i),
  .stat_clr_i   (stat_clr_i),
  .lrck_rise    (lrck_rise),
  .period_cnt   (period_cnt),
  .in_sync_o    (in_sync_o),
  .mute_o       (mute_o),
  .freeze_o     (freeze_o),
  .stat_sticky_o(stat_sticky_o)
);

// File: tb/test_clk_ratio_mon.sv
module test_clk_ratio_mon;
  localparam int unsigned CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lrck = 1'b0;
  logic             lock = 1'b1;
  logic [CNT_W-1:0] ratio = CNT_W'(64);
  logic             det_en = 1'b1;
  logic             clr = 1'b0;
  logic             mute, freeze, in_sync, sticky;
  int               total = 0;
  int               bad = 0;

  always #2 clk = ~clk;

  clk_ratio_mon #(.CNT_W(CNT_W)) i_clk_ratio_mon (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lrck_i       (lrck),
    .pll_lock_i   (lock),
    .ratio_n_i    (ratio),
    .det_en_i     (det_en),
    .stat_clr_i   (clr),
    .mute_o       (mute),
    .freeze_o     (freeze),
    .in_sync_o    (in_sync),
    .stat_sticky_o(sticky)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run(input int p, input int k);
    for (int j = 0; j < k; j++) begin
      lrck = 1'b1;
      idle(p / 2);
      lrck = 1'b0;
      idle(p - p / 2);
    end
  endtask

  // one period of length p, closed by a nominal period
  task automatic probe(input int p);
    run(p, 1);
    run(64, 1);
  endtask

  task automatic t_reset;
    chk(in_sync, 1'b0, "R1 in_sync at reset");
    chk(sticky, 1'b0, "R1 sticky at reset");
    chk(mute, 1'b1, "R1 mute at reset");
    chk(freeze, 1'b1, "R1 freeze at reset");
  endtask

  task automatic t_acquire;
    run(64, 2);
    chk(in_sync, 1'b0, "R5 first period discarded, one good so far");
    chk(mute, 1'b1, "R6 still muted after one good period");
    run(64, 1);
    chk(in_sync, 1'b1, "R6 sync after two good periods");
    chk(mute, 1'b0, "R7 mute released");
    chk(freeze, 1'b0, "R7 freeze released");
  endtask

  task automatic t_window;
    probe(68);
    chk(in_sync, 1'b1, "R2 N+4 accepted");
    probe(60);
    chk(in_sync, 1'b1, "R2 N-4 accepted");
    chk(sticky, 1'b0, "R2 no event inside window");
    probe(69);
    chk(in_sync, 1'b0, "R3 N+5 rejected");
    chk(mute, 1'b1, "R7 mute on N+5");
    chk(sticky, 1'b1, "R10 sticky on N+5");
    run(64, 1);
    chk(in_sync, 1'b0, "R6 one good after bad");
    run(64, 1);
    chk(in_sync, 1'b1, "R6 resync after two good");
    probe(59);
    chk(in_sync, 1'b0, "R3 N-5 rejected");
    run(64, 2);
    chk(in_sync, 1'b1, "R3 resync after N-5");
  endtask

  task automatic t_clear;
    clr = 1'b1;
    idle(1);
    clr = 1'b0;
    idle(1);
    chk(sticky, 1'b0, "R10 sticky cleared by pulse");
    run(64, 1);
    chk(sticky, 1'b0, "R10 sticky stays clear while in sync");
  endtask

  task automatic t_lock;
    lock = 1'b0;
    idle(2);
    chk(in_sync, 1'b0, "R4 lock loss drops sync");
    chk(mute, 1'b1, "R4 lock loss mutes");
    chk(sticky, 1'b1, "R10 sticky on lock loss");
    lock = 1'b1;
    run(64, 2);
    chk(in_sync, 1'b0, "R5 re-arm period after lock discarded");
    run(64, 1);
    chk(in_sync, 1'b1, "R5 sync on third edge after lock");
  endtask

  task automatic t_disable;
    det_en = 1'b0;
    idle(2);
    chk(mute, 1'b0, "R8 no mute while disabled");
    probe(80);
    chk(in_sync, 1'b0, "R8 desync still detected");
    chk(mute, 1'b0, "R8 mute held off");
    chk(freeze, 1'b0, "R8 freeze held off");
    chk(sticky, 1'b1, "R8 sticky still records");
    det_en = 1'b1;
    idle(2);
    chk(mute, 1'b1, "R7 mute once enabled while desynced");
    run(64, 2);
    chk(in_sync, 1'b1, "R6 recovered after disable test");
    chk(mute, 1'b0, "R7 mute released after recovery");
  endtask

  task automatic t_stall;
    idle(3000);
    chk(in_sync, 1'b1, "R9 no flag before saturation");
    idle(1200);
    chk(in_sync, 1'b0, "R9 stopped LRCK flagged");
    chk(mute, 1'b1, "R9 stopped LRCK mutes");
    idle(4200);
    chk(in_sync, 1'b0, "R9 counter held, no wrap");
    run(64, 2);
    chk(in_sync, 1'b0, "R9 saturated period rejected");
    run(64, 1);
    chk(in_sync, 1'b1, "R9 recovery after stall");
  endtask

  task automatic t_ratio;
    ratio = CNT_W'(100);
    run(100, 2);
    chk(in_sync, 1'b0, "R11 old ratio now rejected");
    run(100, 1);
    chk(in_sync, 1'b1, "R11 new ratio accepted");
    probe(104);
    chk(in_sync, 1'b1, "R11 new N+4 accepted");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    chk(mute, 1'b1, "R1 mute first cycle after reset");
    t_acquire();
    t_window();
    t_clear();
    t_lock();
    t_disable();
    t_stall();
    t_ratio();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule